// File: doc/BRIEF.md
# Instruction Address Generation Unit

This block produces every address a 16-bit word-addressed load/store processor needs outside the register file: the next program counter and the memory address register value. It holds the program counter, computes the incremented PC for sequential fetch, and contains one address adder. The adder's first operand is either the current PC or a base register value. Its second operand is zero, the sign-extended low six instruction bits, or the sign-extended low nine instruction bits. The PC is expected to have been advanced during fetch, so the PC-relative forms add their offset to the incremented PC.

An external control unit drives small select codes every cycle. These codes choose the adder operands, the source of the next PC (incremented PC, adder result or bus value) and the source of the memory address (adder result or the zero-extended 8-bit trap vector from the instruction). The adder result is also brought out by itself, so that an effective-address instruction can write it to a register without any memory access. A register jump routes the base register through the adder with a zero offset, so any 16-bit target can be reached.

Top module: `agu_top`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets pcOut to x3000 at that edge, whatever pcLoad is.
- R2: When pcLoad is high at a rising edge outside reset, pcOut takes the value pcNext had before the edge; when pcLoad is low, pcOut keeps its value.
- R3: addrOut equals the first operand plus the second operand, modulo 2^16. The first operand is pcOut when addr1Sel=0 and baseVal when addr1Sel=1.
- R4: The second adder operand is zero for addr2Sel=0 and addr2Sel=3, instr[5:0] sign-extended to 16 bits for addr2Sel=1, and instr[8:0] sign-extended to 16 bits for addr2Sel=2.
- R5: pcNext is pcOut+1 for pcSel=0 and pcSel=3, addrOut for pcSel=1, and busVal for pcSel=2.
- R6: The incremented PC wraps from xFFFF to x0000 with no other effect.
- R7: marOut equals addrOut when marSel=0. When marSel=1 it equals instr[7:0] zero-extended to 16 bits, and the upper eight bits are zero.
- R8: addrOut always shows the adder result, including when marSel=1 and when pcSel does not select it, so the computed effective address can be written to a register.
- R9: With addr1Sel=1, addr2Sel=0, pcSel=1 and pcLoad=1, the PC becomes the full 16-bit baseVal, whatever the instruction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction register contents |
| baseVal | input | 16 | Base register value from the register file |
| busVal | input | 16 | Bus value, the PC source for trap |
| addr1Sel | input | 1 | First adder operand: 0 = PC, 1 = base register |
| addr2Sel | input | 2 | Second adder operand: 0/3 = zero, 1 = 6-bit offset, 2 = 9-bit offset |
| pcSel | input | 2 | Next-PC source: 0/3 = PC+1, 1 = adder, 2 = bus |
| marSel | input | 1 | MAR source: 0 = adder, 1 = trap vector |
| pcLoad | input | 1 | PC load enable |
| pcOut | output | 16 | Current program counter |
| pcNext | output | 16 | Selected next-PC value |
| addrOut | output | 16 | Address adder result |
| marOut | output | 16 | Selected memory address value |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, 9-bit and 6-bit offsets, an 8-bit trap vector and a reset PC of x3000. These values put the sign bits of both offset fields, the xFFFF-to-x0000 wrap of the incremented PC and the zero-extension of vector bytes with high bits set within reach of directed cases. A long random run then covers mixed combinations of selects, offsets and load enables, and the PC drifts across the whole address space while it runs.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    OFF_ZERO = 2'd0,
    OFF_SIX  = 2'd1,
    OFF_NINE = 2'd2,
    OFF_RSVD = 2'd3
  } offSel_e;

  typedef enum logic [1:0] {
    PCS_INC   = 2'd0,
    PCS_ADDER = 2'd1,
    PCS_BUS   = 2'd2,
    PCS_RSVD  = 2'd3
  } pcSel_e;

  // one-hot style strobes from control to datapath
  typedef struct packed {
    logic op1Base;
    logic offSix;
    logic offNine;
    logic pcInc;
    logic pcAdder;
    logic pcBus;
    logic marVec;
    logic loadPc;
  } aguStrobes_t;

endpackage

// File: rtl/agu_sext.sv
module agu_sext #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  inBits,
  output logic [OUT_W-1:0] outWord
);
  localparam int PAD_W = OUT_W - IN_W;

  assign outWord = {{PAD_W{inBits[IN_W-1]}}, inBits};
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        addr1Sel,
  input  logic [1:0]  addr2Sel,
  input  logic [1:0]  pcSel,
  input  logic        marSel,
  input  logic        pcLoad,
  output aguStrobes_t strb
);
  offSel_e offCode;
  pcSel_e  pcCode;

  assign offCode = offSel_e'(addr2Sel);
  assign pcCode  = pcSel_e'(pcSel);

  always_comb begin
    strb         = '0;
    strb.op1Base = addr1Sel;
    strb.marVec  = marSel;
    strb.loadPc  = pcLoad;
    case (offCode)
      OFF_SIX:  strb.offSix  = 1'b1;
      OFF_NINE: strb.offNine = 1'b1;
      default:  ;
    endcase
    case (pcCode)
      PCS_ADDER: strb.pcAdder = 1'b1;
      PCS_BUS:   strb.pcBus   = 1'b1;
      default:   strb.pcInc   = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int          WORD_W   = 16,
  parameter int          OFF9_W   = 9,
  parameter int          OFF6_W   = 6,
  parameter int          VEC_W    = 8,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  aguStrobes_t       strb,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [WORD_W-1:0] busVal,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] pcNext,
  output logic [WORD_W-1:0] addrOut,
  output logic [WORD_W-1:0] marOut
);
  localparam int VEC_PAD = WORD_W - VEC_W;

  logic [WORD_W-1:0] pcReg;
  logic [WORD_W-1:0] sext6, sext9;
  logic [WORD_W-1:0] op1, offWord, sumWord, incWord, vecWord;

  agu_sext #(.IN_W(OFF6_W), .OUT_W(WORD_W)) uSext6 (
    .inBits(instr[OFF6_W-1:0]), .outWord(sext6)
  );
  agu_sext #(.IN_W(OFF9_W), .OUT_W(WORD_W)) uSext9 (
    .inBits(instr[OFF9_W-1:0]), .outWord(sext9)
  );

  assign op1     = strb.op1Base ? baseVal : pcReg;
  assign offWord = ({WORD_W{strb.offSix}}  & sext6)
                 | ({WORD_W{strb.offNine}} & sext9);
  assign sumWord = op1 + offWord;
  assign incWord = pcReg + WORD_W'(1);
  assign vecWord = {{VEC_PAD{1'b0}}, instr[VEC_W-1:0]};

  assign pcNext  = ({WORD_W{strb.pcInc}}   & incWord)
                 | ({WORD_W{strb.pcAdder}} & sumWord)
                 | ({WORD_W{strb.pcBus}}   & busVal);
  assign marOut  = strb.marVec ? vecWord : sumWord;
  assign addrOut = sumWord;
  assign pcOut   = pcReg;

  always_ff @(posedge clk) begin
    if (rst)              pcReg <= WORD_W'(RESET_PC);
    else if (strb.loadPc) pcReg <= pcNext;
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int          WORD_W   = 16,
  parameter int          OFF9_W   = 9,
  parameter int          OFF6_W   = 6,
  parameter int          VEC_W    = 8,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [WORD_W-1:0] busVal,
  input  logic              addr1Sel,
  input  logic [1:0]        addr2Sel,
  input  logic [1:0]        pcSel,
  input  logic              marSel,
  input  logic              pcLoad,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] pcNext,
  output logic [WORD_W-1:0] addrOut,
  output logic [WORD_W-1:0] marOut
);
  aguStrobes_t strb;

  agu_ctrl uCtrl (
    .addr1Sel(addr1Sel), .addr2Sel(addr2Sel), .pcSel(pcSel),
    .marSel(marSel), .pcLoad(pcLoad), .strb(strb)
  );

  agu_datapath #(
    .WORD_W(WORD_W), .OFF9_W(OFF9_W), .OFF6_W(OFF6_W),
    .VEC_W(VEC_W), .RESET_PC(RESET_PC)
  ) uDp (
    .clk(clk), .rst(rst), .strb(strb), .instr(instr),
    .baseVal(baseVal), .busVal(busVal), .pcOut(pcOut),
    .pcNext(pcNext), .addrOut(addrOut), .marOut(marOut)
  );
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] baseVal,
  input logic              addr1Sel,
  input logic [1:0]        addr2Sel,
  input logic [1:0]        pcSel,
  input logic              marSel,
  input logic              pcLoad,
  input logic [WORD_W-1:0] pcOut,
  input logic [WORD_W-1:0] pcNext,
  input logic [WORD_W-1:0] addrOut,
  input logic [WORD_W-1:0] marOut
);
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pcLoad |=> $stable(pcOut)); // R2

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    pcLoad |=> pcOut == $past(pcNext)); // R2

  AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (!addr1Sel && (addr2Sel == 2'd0 || addr2Sel == 2'd3)) |-> addrOut == pcOut); // R4

  AST_PC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pcLoad && pcSel == 2'd0 && pcOut == '1) |=> pcOut == '0); // R6

  AST_VEC_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    marSel |-> marOut[WORD_W-1:VEC_W] == '0); // R7

  AST_MAR_ADDER: assert property (@(posedge clk) disable iff (rst)
    !marSel |-> marOut == addrOut); // R7

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (addr1Sel && addr2Sel == 2'd0 && pcSel == 2'd1 && pcLoad) |=> pcOut == $past(baseVal)); // R9
endmodule

bind agu_top agu_checker #(.WORD_W(WORD_W), .VEC_W(VEC_W)) uChk (
  .clk(clk), .rst(rst), .instr(instr), .baseVal(baseVal),
  .addr1Sel(addr1Sel), .addr2Sel(addr2Sel), .pcSel(pcSel),
  .marSel(marSel), .pcLoad(pcLoad), .pcOut(pcOut), .pcNext(pcNext),
  .addrOut(addrOut), .marOut(marOut)
);

// File: tb/tb_agu_top.sv
module tb_agu_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr, baseVal, busVal;
  logic        addr1Sel, marSel, pcLoad;
  logic [1:0]  addr2Sel, pcSel;
  logic [15:0] pcOut, pcNext, addrOut, marOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int mPc;
  int expNext;

  always #10 clk = ~clk;

  agu_top dut (
    .clk(clk), .rst(rst), .instr(instr), .baseVal(baseVal), .busVal(busVal),
    .addr1Sel(addr1Sel), .addr2Sel(addr2Sel), .pcSel(pcSel), .marSel(marSel),
    .pcLoad(pcLoad), .pcOut(pcOut), .pcNext(pcNext), .addrOut(addrOut),
    .marOut(marOut)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sextField(input int v, input int bits);
    int m = v & ((1 << bits) - 1);
    if (m >= (1 << (bits - 1))) m = m - (1 << bits);
    return m;
  endfunction

  // One clock: drive at the falling edge, compare, then follow the rising edge.
  task automatic step(input string tag, input bit r, input int ir, input int base,
                      input int bus, input bit a1, input int a2, input int ps,
                      input bit ms, input bit ld);
    int op1, off, sum, mar;
    @(negedge clk);
    rst = r; instr = 16'(ir); baseVal = 16'(base); busVal = 16'(bus);
    addr1Sel = a1; addr2Sel = 2'(a2); pcSel = 2'(ps); marSel = ms; pcLoad = ld;
    #2;
    op1 = a1 ? (base & 16'hFFFF) : mPc;
    off = (a2 == 1) ? sextField(ir, 6) : (a2 == 2) ? sextField(ir, 9) : 0;
    sum = (op1 + off + 65536) % 65536;
    if (ps == 1)      expNext = sum;
    else if (ps == 2) expNext = bus & 16'hFFFF;
    else              expNext = (mPc + 1) % 65536;
    mar = ms ? (ir & 255) : sum;
    if (!r) begin
      check(tag, "pcOut", int'(pcOut), mPc);
      check(tag, "addrOut", int'(addrOut), sum);
      check(tag, "pcNext", int'(pcNext), expNext);
      check(tag, "marOut", int'(marOut), mar);
    end
    @(posedge clk);
    if (r)       mPc = 16'h3000;
    else if (ld) mPc = expNext;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mPc = 0;
    rst = 1'b1; instr = '0; baseVal = '0; busVal = '0;
    addr1Sel = 0; addr2Sel = 0; pcSel = 0; marSel = 0; pcLoad = 0;
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R1: reset value, no load
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R1", "pcOut after reset", int'(pcOut), 16'h3000);
    // R5: sequential fetch
    for (int i = 0; i < 3; i++) step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R2: no load while selects point elsewhere
    step("R2", 0, 16'h01FF, 16'h1234, 16'h5555, 0, 2, 1, 0, 0);
    step("R2", 0, 0, 16'h1234, 16'h5555, 1, 0, 2, 0, 0);
    // R3/R4: offsets with both signs
    step("R4", 0, 16'h01FF, 0, 0, 0, 2, 1, 0, 0);
    step("R4", 0, 16'h00FF, 0, 0, 0, 2, 1, 0, 1);
    step("R4", 0, 16'h0020, 16'h8000, 0, 1, 1, 1, 0, 0);
    step("R4", 0, 16'hFE1F, 16'h7FF0, 0, 1, 1, 1, 0, 0);
    step("R4", 0, 16'hFFFF, 16'h0100, 0, 1, 3, 1, 0, 0);
    step("R3", 0, 16'h0100, 16'hFFFF, 0, 1, 2, 1, 0, 1);
    // R9: register jump
    step("R9", 0, 16'hFFFF, 16'hBEEF, 0, 1, 0, 1, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R9", "jump target", int'(pcOut), 16'hBEEF);
    // R5: bus source and reserved code
    step("R5", 0, 0, 0, 16'h0400, 0, 0, 2, 0, 1);
    step("R5", 0, 0, 0, 16'h0999, 0, 0, 3, 0, 1);
    // R6: wrap
    step("R6", 0, 0, 0, 16'hFFFF, 0, 0, 2, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R6", "pcOut after wrap", int'(pcOut), 0);
    // R7/R8: trap vector on MAR, adder still visible
    step("R7", 0, 16'hF025, 0, 0, 0, 2, 0, 1, 0);
    step("R7", 0, 16'hFFAB, 16'h2000, 0, 1, 1, 0, 1, 0);
    step("R8", 0, 16'h0003, 16'h4000, 0, 0, 2, 0, 1, 0);
    step("R8", 0, 16'h0005, 16'h4000, 0, 1, 1, 2, 1, 0);
    // R1: reset while loading
    step("R1", 1, 0, 0, 16'h7777, 0, 0, 2, 0, 1);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R1", "pcOut after mid-run reset", int'(pcOut), 16'h3000);
    // R3: random mix
    for (int i = 0; i < 400; i++)
      step("R3", 0, $urandom, $urandom, $urandom, 1'($urandom), int'($urandom % 4),
           int'($urandom % 4), 1'($urandom), 1'($urandom));
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule